// File: doc/BRIEF.md
# Dual Second-Order Bit-Stream Modulator

This block holds two fully digital second-order delta-sigma modulators. Each one turns a signed multibit sample into a one-bit stream whose density of ones follows the sample value, for use in arithmetic done directly on bit-streams. Each modulator integrates the difference between its input and its own fed-back output in two stages, and then makes a one-bit decision. A logic gate that combines two streams only gives the expected product or sum on average if the streams carry independent quantization noise. For that reason the two loops are built differently: loop A is a cascade of integrators with feedback into both stages, and loop B feeds both integrator outputs forward into the decision.

A compile-time parameter chooses how the output bit is read. In bipolar mapping the bit stands for +full-scale or -full-scale. In unipolar mapping it stands for full-scale or zero, and the fed-back value changes to match. A shared clock enable advances the loops. A mode input slows loop B to every second enable, which gives a further way to decorrelate the two streams.

Top module: `dsm_pair`

## Requirements
- R1: While `rst_n` is low, both output bits read 0 whatever `ce` does, and every integrator is cleared to zero.
- R2: Loop A, on each enabled clock, with feedback f equal to +FS when its output bit is 1, else -FS (bipolar) or 0 (unipolar), where FS = 2^(IN_W-1): u1 <= sat(u1 + x - f), u2 <= sat(u2 + u1_new - f), and the bit becomes 1 exactly when u2_new > 0.
- R3: Loop B, on each step, with f as in R2: v1 <= sat(v1 + x - f), v2 <= sat(v2 + v1_old), and the bit becomes 1 exactly when 2*v1_new + v2_new > 0.
- R4: When `ce` is low, neither output bit nor any integrator changes.
- R5: In bipolar mapping with a constant input x, the count of ones over 1024 enabled clocks from reset lies within 8 of 1024*(x+FS)/(2*FS) for both loops.
- R6: In unipolar mapping with a constant input x in [0, FS), the count of ones over 1024 enabled clocks lies within 8 of 1024*x/FS for both loops.
- R7: With `b_half` high, loop A steps on every enable, and loop B steps only on the 2nd, 4th, 6th ... enable counted from reset. Loop B never steps on a clock where loop A does not.
- R8: Every integrator saturates at -2^(ACC_W-1) and 2^(ACC_W-1)-1 instead of wrapping, and once the input comes back into range the loops continue from the clamped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Clock enable that advances the loops |
| b_half | input | 1 | When high, loop B steps on every second enable |
| a_in | input | IN_W | Signed sample for loop A |
| b_in | input | IN_W | Signed sample for loop B |
| a_bit | output | 1 | Bit-stream of loop A |
| b_bit | output | 1 | Bit-stream of loop B |

## Verification
Two instances run side by side, one per mapping, against an arithmetic model of both loop recurrences. The model is compared bit for bit on every clock. A sweep of constant inputs from the negative to the positive side of the range separates the loop A and loop B equations, because their streams diverge once the input is not zero. Long constant runs check the density of ones against the value, which tells the bipolar mapping apart from the unipolar one. Gapped enable patterns, the half-rate mode, and an out-of-range negative input that drives the integrators into their clamps isolate the hold, rate-gating and saturation behaviour.

// File: rtl/dsm_pair_pkg.sv
package dsm_pair_pkg;
  typedef enum logic {
    MAP_UNIPOLAR = 1'b0,
    MAP_BIPOLAR  = 1'b1
  } map_e;
endpackage

// File: rtl/dsm_integ.sv
module dsm_integ #(
  parameter int ACC_W = 24,
  parameter int EW    = 27
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic signed [EW-1:0]    inc,
  output logic signed [ACC_W-1:0] q,
  output logic signed [ACC_W-1:0] nxt
);
  localparam logic signed [EW-1:0] TOP = {{(EW-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [EW-1:0] BOT = {{(EW-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] TOP_Q = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] BOT_Q = {1'b1, {(ACC_W-1){1'b0}}};

  function automatic logic signed [ACC_W-1:0] clamp(input logic signed [EW-1:0] v);
    if (v > TOP)      return TOP_Q;
    else if (v < BOT) return BOT_Q;
    else              return v[ACC_W-1:0];
  endfunction

  logic signed [EW-1:0] sum;
  assign sum = EW'(q) + inc;
  assign nxt = clamp(sum);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (step) q <= nxt;
  end

  // R8
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && q == TOP_Q && inc >= 0) |=> (q == TOP_Q));
  // R8
  sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && q == BOT_Q && inc <= 0) |=> (q == BOT_Q));
endmodule

// File: rtl/dsm_loop_a.sv
module dsm_loop_a
  import dsm_pair_pkg::*;
#(
  parameter int   IN_W  = 16,
  parameter int   ACC_W = 24,
  parameter map_e MAP   = MAP_BIPOLAR
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step,
  input  logic signed [IN_W-1:0] x,
  output logic                   bit_o
);
  localparam int EW = ACC_W + 3;
  localparam logic signed [EW-1:0] FS = {{(EW-IN_W){1'b0}}, 1'b1, {(IN_W-1){1'b0}}};

  function automatic logic signed [EW-1:0] fb_of(input logic b);
    if (b)                     return FS;
    else if (MAP == MAP_BIPOLAR) return -FS;
    else                       return '0;
  endfunction

  logic signed [EW-1:0]    xe, fbv, inc1, inc2;
  logic signed [ACC_W-1:0] u1_q, u1_n, u2_q, u2_n;
  logic                    decide;

  assign xe   = EW'(x);
  assign fbv  = fb_of(bit_o);
  assign inc1 = xe - fbv;
  assign inc2 = EW'(u1_n) - fbv;

  dsm_integ #(.ACC_W(ACC_W), .EW(EW)) u_int1 (
    .clk(clk), .rst_n(rst_n), .step(step), .inc(inc1), .q(u1_q), .nxt(u1_n));
  dsm_integ #(.ACC_W(ACC_W), .EW(EW)) u_int2 (
    .clk(clk), .rst_n(rst_n), .step(step), .inc(inc2), .q(u2_q), .nxt(u2_n));

  assign decide = (u2_n > 0);

  always_ff @(posedge clk) begin
    if (!rst_n)    bit_o <= 1'b0;
    else if (step) bit_o <= decide;
  end

  // R2
  a_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (bit_o == (u2_q > 0)));
  // R4
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(u1_q) && $stable(u2_q) && $stable(bit_o)));
endmodule

// File: rtl/dsm_loop_b.sv
module dsm_loop_b
  import dsm_pair_pkg::*;
#(
  parameter int   IN_W  = 16,
  parameter int   ACC_W = 24,
  parameter map_e MAP   = MAP_BIPOLAR
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step,
  input  logic signed [IN_W-1:0] x,
  output logic                   bit_o
);
  localparam int EW = ACC_W + 3;
  localparam logic signed [EW-1:0] FS = {{(EW-IN_W){1'b0}}, 1'b1, {(IN_W-1){1'b0}}};

  function automatic logic signed [EW-1:0] fb_of(input logic b);
    if (b)                     return FS;
    else if (MAP == MAP_BIPOLAR) return -FS;
    else                       return '0;
  endfunction

  function automatic logic signed [EW-1:0] weigh(input logic signed [ACC_W-1:0] s1,
                                                 input logic signed [ACC_W-1:0] s2);
    return (EW'(s1) <<< 1) + EW'(s2);
  endfunction

  logic signed [EW-1:0]    xe, fbv, inc1, inc2, vsum;
  logic signed [ACC_W-1:0] v1_q, v1_n, v2_q, v2_n;

  assign xe   = EW'(x);
  assign fbv  = fb_of(bit_o);
  assign inc1 = xe - fbv;
  assign inc2 = EW'(v1_q);

  dsm_integ #(.ACC_W(ACC_W), .EW(EW)) u_int1 (
    .clk(clk), .rst_n(rst_n), .step(step), .inc(inc1), .q(v1_q), .nxt(v1_n));
  dsm_integ #(.ACC_W(ACC_W), .EW(EW)) u_int2 (
    .clk(clk), .rst_n(rst_n), .step(step), .inc(inc2), .q(v2_q), .nxt(v2_n));

  assign vsum = weigh(v1_n, v2_n);

  always_ff @(posedge clk) begin
    if (!rst_n)    bit_o <= 1'b0;
    else if (step) bit_o <= (vsum > 0);
  end

  // R3
  b_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (bit_o == (weigh(v1_q, v2_q) > 0)));
  // R4
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(v1_q) && $stable(v2_q) && $stable(bit_o)));
endmodule

// File: rtl/dsm_pair.sv
module dsm_pair
  import dsm_pair_pkg::*;
#(
  parameter int   IN_W  = 16,
  parameter int   ACC_W = 24,
  parameter map_e MAP   = MAP_BIPOLAR
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce,
  input  logic                   b_half,
  input  logic signed [IN_W-1:0] a_in,
  input  logic signed [IN_W-1:0] b_in,
  output logic                   a_bit,
  output logic                   b_bit
);
  logic phase;
  logic a_step, b_step;

  always_ff @(posedge clk) begin
    if (!rst_n)  phase <= 1'b0;
    else if (ce) phase <= ~phase;
  end

  assign a_step = ce;
  assign b_step = ce & (~b_half | phase);

  dsm_loop_a #(.IN_W(IN_W), .ACC_W(ACC_W), .MAP(MAP)) u_loop_a (
    .clk(clk), .rst_n(rst_n), .step(a_step), .x(a_in), .bit_o(a_bit));
  dsm_loop_b #(.IN_W(IN_W), .ACC_W(ACC_W), .MAP(MAP)) u_loop_b (
    .clk(clk), .rst_n(rst_n), .step(b_step), .x(b_in), .bit_o(b_bit));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(a_bit) && $stable(b_bit)));
  // R7
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_half && b_step) |=> (b_half -> !b_step));
  // R7
  b_with_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_step |-> a_step);
endmodule

// File: tb/dsm_pair_tb.sv
module dsm_pair_tb;
  import dsm_pair_pkg::*;

  localparam longint FS  = 32768;
  localparam longint TOP = 64'sd8388607;
  localparam longint BOT = -64'sd8388608;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ce = 1'b0, b_half = 1'b0;
  logic signed [15:0] xbip = '0, xuni = '0;
  logic ab0, bb0, ab1, bb1;

  always #2 clk = ~clk;

  dsm_pair #(.IN_W(16), .ACC_W(24), .MAP(MAP_BIPOLAR)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .b_half(b_half),
    .a_in(xbip), .b_in(xbip), .a_bit(ab0), .b_bit(bb0));
  dsm_pair #(.IN_W(16), .ACC_W(24), .MAP(MAP_UNIPOLAR)) u_dut_uni (
    .clk(clk), .rst_n(rst_n), .ce(ce), .b_half(b_half),
    .a_in(xuni), .b_in(xuni), .a_bit(ab1), .b_bit(bb1));

  int checks = 0, errors = 0;
  longint ma1[2], ma2[2], mb1[2], mb2[2];
  bit mya[2], myb[2];
  int en_cnt;
  int ones_a0, ones_b0, ones_a1, ones_b1;

  function automatic longint lim(longint v);
    if (v > TOP) return TOP;
    if (v < BOT) return BOT;
    return v;
  endfunction

  // k = 0: bipolar instance, k = 1: unipolar instance
  function automatic longint fbk(bit y, int k);
    if (y) return FS;
    return (k == 0) ? -FS : 64'sd0;
  endfunction

  task automatic model_step(int k, longint x, bit do_b);
    longint f, n1, n2;
    f  = fbk(mya[k], k);
    n1 = lim(ma1[k] + x - f);
    n2 = lim(ma2[k] + n1 - f);
    ma1[k] = n1; ma2[k] = n2; mya[k] = (n2 > 0);
    if (do_b) begin
      f  = fbk(myb[k], k);
      n1 = lim(mb1[k] + x - f);
      n2 = lim(mb2[k] + mb1[k]);
      myb[k] = (2 * n1 + n2 > 0);
      mb1[k] = n1; mb2[k] = n2;
    end
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(bit half);
    rst_n = 1'b0; ce = 1'b1; b_half = half;
    for (int k = 0; k < 2; k++) begin
      ma1[k] = 0; ma2[k] = 0; mb1[k] = 0; mb2[k] = 0; mya[k] = 0; myb[k] = 0;
    end
    en_cnt = 0;
    ones_a0 = 0; ones_b0 = 0; ones_a1 = 0; ones_b1 = 0;
    repeat (3) @(negedge clk);
    chk({ab0, bb0, ab1, bb1} == 4'b0000, "R1", "bits in reset", {ab0, bb0, ab1, bb1}, 0);
    rst_n = 1'b1; ce = 1'b0;
    @(negedge clk);
    chk({ab0, bb0, ab1, bb1} == 4'b0000, "R1", "bits after reset", {ab0, bb0, ab1, bb1}, 0);
  endtask

  task automatic tick(bit c, int xb, int xu, string req);
    bit do_b;
    logic [3:0] prev;
    prev = {ab0, bb0, ab1, bb1};
    xbip = 16'(xb); xuni = 16'(xu); ce = c;
    if (c) begin
      en_cnt++;
      do_b = !b_half || (en_cnt % 2 == 0);
      model_step(0, xb, do_b);
      model_step(1, xu, do_b);
    end
    @(negedge clk);
    chk(ab0 == mya[0], req, "loop A bipolar", ab0, mya[0]);
    chk(bb0 == myb[0], req, "loop B bipolar", bb0, myb[0]);
    chk(ab1 == mya[1], req, "loop A unipolar", ab1, mya[1]);
    chk(bb1 == myb[1], req, "loop B unipolar", bb1, myb[1]);
    if (!c) chk({ab0, bb0, ab1, bb1} == prev, "R4", "hold with ce low", {ab0, bb0, ab1, bb1}, prev);
    ones_a0 += ab0; ones_b0 += bb0; ones_a1 += ab1; ones_b1 += bb1;
  endtask

  task automatic dens(int xb, int xu);
    longint eb, eu;
    do_reset(1'b0);
    repeat (1024) tick(1'b1, xb, xu, "R2 R3");
    eb = (longint'(xb) + FS) * 1024 / (2 * FS);
    eu = longint'(xu) * 1024 / FS;
    chk((ones_a0 - eb <= 8) && (eb - ones_a0 <= 8), "R5", "loop A bipolar density", ones_a0, eb);
    chk((ones_b0 - eb <= 8) && (eb - ones_b0 <= 8), "R5", "loop B bipolar density", ones_b0, eb);
    chk((ones_a1 - eu <= 8) && (eu - ones_a1 <= 8), "R6", "loop A unipolar density", ones_a1, eu);
    chk((ones_b1 - eu <= 8) && (eu - ones_b1 <= 8), "R6", "loop B unipolar density", ones_b1, eu);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state, R2/R3 recurrences over a sweep of constant inputs
    begin
      int sweep[8] = '{-16384, -8192, -1000, 0, 1, 5000, 12000, 16383};
      for (int i = 0; i < 8; i++) begin
        do_reset(1'b0);
        repeat (150) tick(1'b1, sweep[i], 2000 + i * 3000, "R2 R3");
      end
    end
    // R5 / R6 densities
    dens(-20000, 4000);
    dens(-3000, 16384);
    dens(0, 10000);
    dens(12000, 24000);
    // R4 gapped enables
    do_reset(1'b0);
    for (int i = 0; i < 300; i++) tick((i % 4) != 1, (i / 50) * 2500 - 6000, 3000 + (i / 50) * 3000, "R4");
    // R7 half-rate loop B
    do_reset(1'b1);
    for (int i = 0; i < 400; i++) tick((i % 5) != 2, 7000 - (i / 50) * 2000, 20000 - (i / 50) * 2000, "R7");
    b_half = 1'b0;
    // R8 saturation with out-of-range negative input on the unipolar instance
    do_reset(1'b0);
    repeat (600) tick(1'b1, 0, -32768, "R8");
    chk(ab1 == 1'b0 && bb1 == 1'b0, "R8", "bits while clamped", {ab1, bb1}, 0);
    repeat (300) tick(1'b1, 0, 16384, "R8");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule